// File: doc/BRIEF.md
# Asymmetric Level-Qualifying Delay

This block is a single-bit clocked delay in which one logic level, the favoured level, reaches the output only after the input has held that level for a programmable number of clock cycles. The other level reaches the output after exactly one cycle. A build-time parameter chooses the variant. The high-favouring variant delays rising transitions. The low-favouring variant delays falling transitions. A burst of the favoured level that is shorter than the programmed length never appears at the output, so the block acts as a glitch filter or qualifier on a single control line.

Internally, a saturating run-length counter tracks how many consecutive favoured samples have been seen. No shift register is used, so storage grows with the logarithm of the maximum delay. The delay length is captured once, on the first favoured sample of each run. A run already in progress keeps the length it started with.

Top module: `asym_level_delay`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the output holds the non-favoured level (0 when favouring high, 1 when favouring low), and any partial run counted before reset is discarded.
- R2: With FAVOR_HIGH=1 and length N, `dout` is 1 in cycle t only if `din` was 1 in each of cycles t-N to t-1. A rising input therefore appears N cycles later.
- R3: A non-favoured input level appears on `dout` exactly one cycle after it is sampled, whatever the programmed length.
- R4: A burst of the favoured level lasting fewer than N cycles never produces the favoured level on `dout`. For example, with N=4 the input 000011111111100000001000000 gives 000000001111110000000000000 when favouring high.
- R5: With FAVOR_HIGH=0 the behaviour is mirrored. A 0 appears after N consecutive 0 samples, and a 1 appears after one cycle.
- R6: With N=1 both variants behave as a plain one-cycle register.
- R7: A `delay_len` value of 0 is treated as 1.
- R8: The length used for a run is the value of `delay_len` on the first favoured sample of that run. Changing `delay_len` during a run does not change when that run reaches the output.
- R9: The run counter saturates. A favoured run longer than N keeps `dout` at the favoured level for as long as the run lasts. The largest length, 32767 with the default width, is honoured exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Data input |
| delay_len | input | CNT_W | Qualification length N in cycles |
| dout | output | 1 | Registered, qualified output |

## Verification
A wrong run count shows up at the ports as a favoured edge arriving early or late. The error is visible in the first cycle of the affected run in which the count would have crossed N. A stale captured length shows up the same way, but only on the run after `delay_len` changes. That is why the length-change test runs two successive runs. A counter that fails to clear on a non-favoured sample lets a later short burst leak through, and this shows within N cycles of that burst. A missing saturation shows up only on runs longer than the counter range, so the maximum-length run is held past its qualifying cycle.

// File: rtl/adl_pkg.sv
package adl_pkg;
   // widest supported run counter
   localparam int ADL_MAX_W = 31;
   // narrowest useful run counter
   localparam int ADL_MIN_W = 2;

   typedef enum logic {
      ADL_LVL_LOW  = 1'b0,
      ADL_LVL_HIGH = 1'b1
   } adl_level_e;
endpackage

// File: rtl/adl_len_latch.sv
module adl_len_latch #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] len_in,
   output logic [CNT_W-1:0] n_use,
   output logic [CNT_W-1:0] n_act_q
);
   localparam logic [CNT_W-1:0] N_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] n_eff;

   // a zero length behaves as the minimum of one cycle
   assign n_eff = (len_in == '0) ? N_ONE : len_in;
   // a new run takes the live length, a running one keeps its captured value
   assign n_use = start ? n_eff : n_act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_act_q <= N_ONE;
      end else if (start) begin
         n_act_q <= n_eff;
      end
   end

   // R7: captured length is never zero
   a_r7_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      n_act_q != '0);
endmodule

// File: rtl/adl_run_counter.sv
module adl_run_counter #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fav,
   input  logic [CNT_W-1:0] n_use,
   output logic [CNT_W-1:0] run_q,
   output logic             reached
);
   logic [CNT_W:0]   cnt_inc;
   logic [CNT_W-1:0] run_d;

   assign cnt_inc = {1'b0, run_q} + {{CNT_W{1'b0}}, 1'b1};
   // the current sample completes a run of at least n_use favoured cycles
   assign reached = fav && (cnt_inc >= {1'b0, n_use});

   always_comb begin
      if (!fav) begin
         run_d = '0;
      end else if (reached) begin
         run_d = n_use;            // saturate at the run length
      end else begin
         run_d = cnt_inc[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else begin
         run_q <= run_d;
      end
   end

   // R3: a non-favoured sample always clears the run
   a_r3_run_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !fav |=> (run_q == '0));
endmodule

// File: rtl/adl_level_map.sv
module adl_level_map #(
   parameter bit FAVOR_HIGH = 1'b1
) (
   input  logic din,
   input  logic reached,
   output logic fav,
   output logic out_lvl
);
   if (FAVOR_HIGH) begin : g_fav_high
      assign fav     = din;
      assign out_lvl = reached;
   end else begin : g_fav_low
      assign fav     = ~din;
      assign out_lvl = ~reached;
   end
endmodule

// File: rtl/asym_level_delay.sv
module asym_level_delay #(
   parameter int CNT_W      = 15,
   parameter bit FAVOR_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [CNT_W-1:0] delay_len,
   output logic             dout
);
   import adl_pkg::*;

   localparam logic FAV_LVL = FAVOR_HIGH ? ADL_LVL_HIGH : ADL_LVL_LOW;

   if (CNT_W < ADL_MIN_W || CNT_W > ADL_MAX_W) begin : g_bad_width
      $error("asym_level_delay: CNT_W out of supported range");
   end

   logic             fav;
   logic             reached;
   logic             out_lvl;
   logic             start;
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] n_use;
   logic [CNT_W-1:0] n_act_q;
   logic             dout_q;

   assign start = fav && (run_q == '0);

   adl_level_map #(.FAVOR_HIGH(FAVOR_HIGH)) u_map (
      .din     (din),
      .reached (reached),
      .fav     (fav),
      .out_lvl (out_lvl)
   );

   adl_len_latch #(.CNT_W(CNT_W)) u_len (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .len_in  (delay_len),
      .n_use   (n_use),
      .n_act_q (n_act_q)
   );

   adl_run_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .fav     (fav),
      .n_use   (n_use),
      .run_q   (run_q),
      .reached (reached)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= ~FAV_LVL;
      end else begin
         dout_q <= out_lvl;
      end
   end

   assign dout = dout_q;

   // R3: a non-favoured input shows at the output one cycle later
   a_r3_fast_level: assert property (@(posedge clk) disable iff (!rst_n)
      (din != FAV_LVL) |=> (dout != FAV_LVL));

   // R2: a favoured output needs a favoured input in the previous cycle
   a_r2_fav_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
      (dout == FAV_LVL) |-> ($past(din) == FAV_LVL));

   // R4: a favoured output only after a full run of the captured length
   a_r4_full_run: assert property (@(posedge clk) disable iff (!rst_n)
      (dout == FAV_LVL) |-> (run_q == n_act_q));

   // R8: the captured length holds while a run continues
   a_r8_len_held: assert property (@(posedge clk) disable iff (!rst_n)
      (fav && (run_q != '0)) |=> $stable(n_act_q));

   // R9: the counter never passes the captured length
   a_r9_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= n_act_q);
endmodule

// File: tb/test_asym_level_delay.sv
`timescale 1ns/1ps
module test_asym_level_delay;
   localparam int CNT_W = 15;

   typedef struct packed {
      logic        fav_hi;
      logic [15:0] n;
      logic [7:0]  len;
      logic [31:0] stim;    // index 0 is bit len-1
      logic [31:0] expv;
      logic [3:0]  tag;     // 2:R2/R4 5:R5 6:R6 7:R7
   } row_t;

   localparam int NROWS = 6;
   localparam row_t ROWS [NROWS] = '{
      '{1'b1, 16'd4, 8'd27, 32'b000011111111100000001000000, 32'b000000001111110000000000000, 4'd2},
      '{1'b0, 16'd4, 8'd27, 32'b111100000000011111110111111, 32'b111111110000001111111111111, 4'd5},
      '{1'b1, 16'd1, 8'd10, 32'b0110100111, 32'b0011010011, 4'd6},
      '{1'b1, 16'd0, 8'd10, 32'b0110100111, 32'b0011010011, 4'd7},
      '{1'b1, 16'd3, 8'd10, 32'b0111011110, 32'b0000100011, 4'd2},
      '{1'b0, 16'd2, 8'd10, 32'b1001000111, 32'b1110110011, 4'd5}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             din = 1'b0;
   logic [CNT_W-1:0] delay_len = '0;
   logic             dout_hi;
   logic             dout_lo;
   int               checks = 0;
   int               errors = 0;
   bit               done = 1'b0;

   always #2.5 clk = ~clk;

   asym_level_delay #(.CNT_W(CNT_W), .FAVOR_HIGH(1'b1)) i_asym_level_delay (
      .clk(clk), .rst_n(rst_n), .din(din), .delay_len(delay_len), .dout(dout_hi));

   asym_level_delay #(.CNT_W(CNT_W), .FAVOR_HIGH(1'b0)) i_asym_level_delay_lo (
      .clk(clk), .rst_n(rst_n), .din(din), .delay_len(delay_len), .dout(dout_lo));

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic apply_reset(input logic lvl);
      @(negedge clk);
      rst_n = 1'b0;
      din = lvl;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state of both variants
      rst_n = 1'b0;
      din = 1'b1;
      delay_len = 15'd4;
      repeat (3) @(negedge clk);
      chk(dout_hi, 1'b0, "R1 reset high variant");
      chk(dout_lo, 1'b1, "R1 reset low variant");

      // table walk: R2 R4 R5 R6 R7
      for (int r = 0; r < NROWS; r++) begin
         delay_len = ROWS[r].n[CNT_W-1:0];
         apply_reset(ROWS[r].fav_hi ? 1'b0 : 1'b1);
         for (int i = 0; i < int'(ROWS[r].len); i++) begin
            logic act;
            logic exp;
            act = ROWS[r].fav_hi ? dout_hi : dout_lo;
            exp = ROWS[r].expv[ROWS[r].len - 1 - i];
            case (ROWS[r].tag)
               4'd2: chk(act, exp, "R2/R4 table row");
               4'd5: chk(act, exp, "R5 table row");
               4'd6: chk(act, exp, "R6 table row");
               default: chk(act, exp, "R7 table row");
            endcase
            din = ROWS[r].stim[ROWS[r].len - 1 - i];
            @(negedge clk);
         end
      end

      // R3: fall passes after one cycle with a long length
      delay_len = 15'd2;
      apply_reset(1'b0);
      din = 1'b1;
      repeat (5) @(negedge clk);
      chk(dout_hi, 1'b1, "R3 setup high qualified");
      delay_len = 15'd300;
      din = 1'b0;
      @(negedge clk);
      chk(dout_hi, 1'b0, "R3 fall after one cycle");

      // R1: reset discards a partial run
      delay_len = 15'd3;
      apply_reset(1'b0);
      din = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(dout_hi, 1'b0, "R1 run cleared by reset");
      @(negedge clk);
      chk(dout_hi, 1'b1, "R1 fresh run qualifies");

      // R8: length captured at run start
      delay_len = 15'd5;
      apply_reset(1'b0);
      din = 1'b1;
      @(negedge clk);
      delay_len = 15'd2;
      repeat (3) @(negedge clk);
      chk(dout_hi, 1'b0, "R8 mid-run change ignored");
      @(negedge clk);
      chk(dout_hi, 1'b1, "R8 original length honoured");
      din = 1'b0;
      @(negedge clk);
      din = 1'b1;
      @(negedge clk);
      chk(dout_hi, 1'b0, "R8 next run one high");
      @(negedge clk);
      chk(dout_hi, 1'b1, "R8 next run uses new length");

      // R9: maximum length and saturation
      delay_len = 15'd32767;
      apply_reset(1'b0);
      din = 1'b1;
      repeat (32766) @(negedge clk);
      chk(dout_hi, 1'b0, "R9 one short of max");
      @(negedge clk);
      chk(dout_hi, 1'b1, "R9 max length reached");
      repeat (20) @(negedge clk);
      chk(dout_hi, 1'b1, "R9 saturated run holds");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule